// File: doc/BRIEF.md
# Shared Memory Front End with Global Store Queue

This block sits between several cores and one small shared memory array in a sequentially consistent system. Each core has one blocking request channel. A core raises a request and holds it until it gets a response. A write is placed in a single first-in first-out store queue that all cores share, and it is acknowledged in the cycle it enters the queue. Later the queue drains one entry per cycle into the memory array. When an entry reaches memory, the block sends a second acknowledgement pulse, called the late acknowledgement, back to the core that issued that write.

Reads take their data from the memory array only. The queue is never searched for a newer value. To keep a core from overtaking its own stores, a read is not accepted while that core still has writes in the queue. Each core has a counter of its queued writes for this purpose. A round-robin arbiter accepts at most one request per cycle. The memory array has one port, and a draining write has priority on it, so a read that would collide with a drain is accepted one cycle later.

Top module: `gsq_shmem`

## Requirements
- R1: After reset `wr_ack`, `late_ack` and `rd_valid` are all low, and every memory word reads as zero.
- R2: A write request that is accepted raises the issuing core's bit of `wr_ack` in the same cycle, combinationally, and raises no other bit. A write is accepted only while the queue has a free slot.
- R3: Queued writes reach memory strictly in the order they were accepted, at most one per cycle. When the memory port is free, the late acknowledgement of a write is seen two cycles after the cycle of its `wr_ack`.
- R4: Each `late_ack` pulse goes only to the core that issued the drained entry (bit c of `late_ack` belongs to core c).
- R5: The read response appears as a one-cycle `rd_valid` pulse for the requesting core, one cycle after the read is accepted. `rd_data` then holds the memory word at the requested address. A read held high through its response cycle produces exactly one pulse.
- R6: A read from a core that still has writes in the queue is not accepted until the late acknowledgements of those writes have arrived. The data it returns then includes that core's own writes.
- R7: With several requesters, the arbiter grants in round-robin order starting after the last granted core, and accepts at most one request per cycle. Two cores that request continuously are granted alternately.
- R8: A read arbitrated in a cycle where a queued write is draining is not accepted in that cycle. The next drain is held off for one cycle, and the read is accepted then, so its `rd_valid` arrives two cycles after it was first raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NC | Per-core request strobe, held until the response |
| req_write | input | NC | Per-core operation: 1 = write, 0 = read |
| req_addr | input | NC*AW | Per-core word address, core c in bits [c*AW +: AW] |
| req_wdata | input | NC*DW | Per-core write data, core c in bits [c*DW +: DW] |
| wr_ack | output | NC | Immediate write acknowledgement, one-hot or zero |
| late_ack | output | NC | Pulse when a core's write has reached memory |
| rd_valid | output | NC | Read response pulse for the addressed core |
| rd_data | output | DW | Read data, valid while a bit of `rd_valid` is high |

## Verification
The bench builds the block with its default values: four cores, an eight-entry queue and sixteen 32-bit words. Four cores are enough to show round-robin alternation between two continuous requesters, and a three-way contention whose late acknowledgements must follow the grant order. With a single-cycle drain, the memory-port conflict of R8 and the own-write hold of R6 both occur at fixed, predictable cycles. This lets the bench check the exact cycle of each response as well as its value.

// File: rtl/gsq_pkg.sv
package gsq_pkg;
  localparam int GSQ_NCORE_DEF = 4;
  localparam int GSQ_DEPTH_DEF = 8;
  localparam int GSQ_WORDS_DEF = 16;
  localparam int GSQ_DW_DEF    = 32;

  typedef enum logic {
    GSQ_READ  = 1'b0,
    GSQ_WRITE = 1'b1
  } gsq_op_e;
endpackage

// File: rtl/gsq_rr_arb.sv
module gsq_rr_arb #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic                 adv,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] gnt_idx,
  output logic                 any
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr_q, ptr_d;

  always_comb begin
    int sum;
    logic [IW-1:0] j;
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int i = 0; i < N; i++) begin
      sum = int'(ptr_q) + i;
      if (sum >= N) sum = sum - N;
      j = IW'(sum);
      if (!any && req[j]) begin
        any     = 1'b1;
        gnt[j]  = 1'b1;
        gnt_idx = j;
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv && any) begin
      ptr_d = (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/gsq_fifo.sv
module gsq_fifo #(
  parameter int W     = 40,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = slot_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
    if (do_pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
    if (do_push && !do_pop)      cnt_d = cnt_q + CW'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wp_q] <= push_data;
  end
endmodule

// File: rtl/gsq_pend_cnt.sv
module gsq_pend_cnt #(
  parameter int CW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic zero
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !dec)      cnt_d = cnt_q + CW'(1);
    else if (dec && !inc) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/gsq_shmem.sv
module gsq_shmem
  import gsq_pkg::*;
#(
  parameter int NC    = GSQ_NCORE_DEF,
  parameter int DEPTH = GSQ_DEPTH_DEF,
  parameter int NW    = GSQ_WORDS_DEF,
  parameter int DW    = GSQ_DW_DEF,
  parameter int AW    = $clog2(NW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NC-1:0]    req_valid,
  input  logic [NC-1:0]    req_write,
  input  logic [NC*AW-1:0] req_addr,
  input  logic [NC*DW-1:0] req_wdata,
  output logic [NC-1:0]    wr_ack,
  output logic [NC-1:0]    late_ack,
  output logic [NC-1:0]    rd_valid,
  output logic [DW-1:0]    rd_data
);
  localparam int CIW = (NC > 1) ? $clog2(NC) : 1;
  localparam int CNW = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [CIW-1:0] core;
    logic [AW-1:0]  addr;
    logic [DW-1:0]  data;
  } ent_t;
  localparam int EW = $bits(ent_t);

  logic [AW-1:0]  addr_c [NC];
  logic [DW-1:0]  data_c [NC];
  logic [NC-1:0]  elig, gnt, own_clear, cnt_inc, cnt_dec;
  logic [CIW-1:0] gnt_idx;
  logic           gnt_any, gnt_wr, drain_fire, acc, push, rd_acc;
  logic           hold_q, hold_d;
  logic           q_empty, q_full;
  ent_t           push_ent, head_ent;
  logic [EW-1:0]  head_bits;

  logic [DW-1:0]  mem_q [NW];
  logic [NC-1:0]  late_q, late_d, rdv_q, rdv_d;
  logic [DW-1:0]  rdat_q, rdat_d;

  // Per-core unpacking, eligibility and pending-write counters
  for (genvar c = 0; c < NC; c++) begin : g_core
    assign addr_c[c] = req_addr[c*AW +: AW];
    assign data_c[c] = req_wdata[c*DW +: DW];
    assign elig[c]   = req_valid[c] && !rdv_q[c] &&
                       ((req_write[c] == GSQ_WRITE) ? !q_full : own_clear[c]);
    assign cnt_inc[c] = push && gnt[c];
    assign cnt_dec[c] = drain_fire && (head_ent.core == CIW'(c));

    gsq_pend_cnt #(.CW(CNW)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (cnt_inc[c]),
      .dec  (cnt_dec[c]),
      .zero (own_clear[c])
    );
  end

  gsq_rr_arb #(.N(NC)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (elig),
    .adv    (acc),
    .gnt    (gnt),
    .gnt_idx(gnt_idx),
    .any    (gnt_any)
  );

  // Drain owns the memory port unless a read was turned away last cycle
  assign gnt_wr     = |(gnt & req_write);
  assign drain_fire = !q_empty && !hold_q;
  assign acc        = gnt_any && (gnt_wr || !drain_fire);
  assign push       = acc && gnt_wr;
  assign rd_acc     = acc && !gnt_wr;
  assign hold_d     = gnt_any && !gnt_wr && drain_fire;

  assign push_ent = '{core: gnt_idx, addr: addr_c[gnt_idx], data: data_c[gnt_idx]};
  assign head_ent = ent_t'(head_bits);

  gsq_fifo #(.W(EW), .DEPTH(DEPTH)) u_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_data(push_ent),
    .pop      (drain_fire),
    .head     (head_bits),
    .empty    (q_empty),
    .full     (q_full)
  );

  // Next-state logic for the response registers
  always_comb begin
    late_d = '0;
    if (drain_fire) late_d[head_ent.core] = 1'b1;
    rdv_d  = rd_acc ? gnt : '0;
    rdat_d = rdat_q;
    if (rd_acc) rdat_d = mem_q[addr_c[gnt_idx]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      late_q <= '0;
      rdv_q  <= '0;
      rdat_q <= '0;
    end else begin
      hold_q <= hold_d;
      late_q <= late_d;
      rdv_q  <= rdv_d;
      rdat_q <= rdat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem_q[i] <= '0;
    end else if (drain_fire) begin
      mem_q[head_ent.addr] <= head_ent.data;
    end
  end

  assign wr_ack   = push ? gnt : '0;
  assign late_ack = late_q;
  assign rd_valid = rdv_q;
  assign rd_data  = rdat_q;
endmodule

// File: rtl/gsq_chk.sv
module gsq_chk #(
  parameter int NC    = 4,
  parameter int DEPTH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NC-1:0] req_valid,
  input logic [NC-1:0] req_write,
  input logic [NC-1:0] wr_ack,
  input logic [NC-1:0] late_ack,
  input logic [NC-1:0] rd_valid
);
  localparam int SW = $clog2(DEPTH + 2) + 1;

  logic [SW-1:0] shadow_q [NC];
  logic [SW+3:0] shadow_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) shadow_q[c] <= '0;
    end else begin
      for (int c = 0; c < NC; c++)
        shadow_q[c] <= shadow_q[c] + SW'(wr_ack[c]) - SW'(late_ack[c]);
    end
  end

  always_comb begin
    shadow_sum = '0;
    for (int c = 0; c < NC; c++) shadow_sum = shadow_sum + (SW+4)'(shadow_q[c]);
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_ack)); // R7
  AST_LATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(late_ack)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_sum <= (SW+4)'(DEPTH + 1)); // R2

  for (genvar c = 0; c < NC; c++) begin : g_chk
    AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ack[c] |-> (req_valid[c] && req_write[c])); // R2
    AST_LATE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
      late_ack[c] |-> (shadow_q[c] != '0)); // R4
    AST_RD_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid[c] |-> (shadow_q[c] == '0)); // R6
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid[c] |-> $past(req_valid[c] && !req_write[c])); // R5
    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid[c] |=> !rd_valid[c]); // R5
  end
endmodule

bind gsq_shmem gsq_chk #(.NC(NC), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .wr_ack   (wr_ack),
  .late_ack (late_ack),
  .rd_valid (rd_valid)
);

// File: tb/sim_gsq_shmem.sv
module sim_gsq_shmem;
  localparam int NC = 4;
  localparam int AW = 4;
  localparam int DW = 32;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NC-1:0]    req_valid, req_write;
  logic [NC*AW-1:0] req_addr;
  logic [NC*DW-1:0] req_wdata;
  logic [NC-1:0]    wr_ack, late_ack, rd_valid;
  logic [DW-1:0]    rd_data;

  int checks = 0;
  int bad    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  gsq_shmem u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .wr_ack(wr_ack),
    .late_ack(late_ack), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(int c, bit wr, int addr, logic [31:0] data);
    req_valid[c] = 1'b1;
    req_write[c] = wr;
    req_addr[c*AW +: AW] = AW'(addr);
    req_wdata[c*DW +: DW] = data;
  endtask

  task automatic idle(int c);
    req_valid[c] = 1'b0;
    req_write[c] = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 wr_ack", 32'(wr_ack), 0);
    chk("R1 late_ack", 32'(late_ack), 0);
    chk("R1 rd_valid", 32'(rd_valid), 0);
    step(); drive(3, 0, 9, 0); #1;
    step(); #1;
    chk("R1 rd_valid core3", 32'(rd_valid), 32'h8);
    chk("R1 zero memory", rd_data, 0);
    idle(3);
  endtask

  task automatic t_write_read();
    step(); drive(0, 1, 3, 32'hA5A5_0001); #1;
    chk("R2 wr_ack same cycle", 32'(wr_ack), 32'h1);
    step(); idle(0); #1;
    chk("R3 no early late_ack", 32'(late_ack), 0);
    step(); #1;
    chk("R4 late_ack to core0", 32'(late_ack), 32'h1);
    step(); drive(1, 0, 3, 0); #1;
    chk("R5 no same-cycle response", 32'(rd_valid), 0);
    step(); #1;
    chk("R5 rd_valid core1", 32'(rd_valid), 32'h2);
    chk("R5 rd_data", rd_data, 32'hA5A5_0001);
    step(); idle(1); #1;
    chk("R5 single pulse", 32'(rd_valid), 0);
  endtask

  task automatic t_own_wait();
    step(); drive(2, 1, 7, 32'h0000_0077); #1;
    chk("R2 wr_ack core2", 32'(wr_ack), 32'h4);
    step(); drive(2, 0, 7, 0); #1;
    chk("R6 read held (c1)", 32'(rd_valid), 0);
    step(); #1;
    chk("R6 late_ack core2", 32'(late_ack), 32'h4);
    chk("R6 read held (c2)", 32'(rd_valid), 0);
    step(); #1;
    chk("R6 rd_valid core2", 32'(rd_valid), 32'h4);
    chk("R6 own data", rd_data, 32'h0000_0077);
    step(); idle(2); #1;
  endtask

  task automatic t_drain_prio();
    step(); drive(0, 1, 5, 32'h0000_0055); #1;
    chk("R8 wr_ack core0", 32'(wr_ack), 32'h1);
    step(); idle(0); drive(1, 0, 5, 0); drive(3, 1, 6, 32'h0000_0066); #1;
    chk("R8 nothing accepted in drain cycle", 32'(wr_ack), 0);
    step(); #1;
    chk("R8 read not yet answered", 32'(rd_valid), 0);
    chk("R8 late_ack core0", 32'(late_ack), 32'h1);
    chk("R8 read wins over write", 32'(wr_ack), 0);
    step(); #1;
    chk("R8 rd_valid two cycles later", 32'(rd_valid), 32'h2);
    chk("R8 rd_data drained value", rd_data, 32'h0000_0055);
    chk("R7 write granted next", 32'(wr_ack), 32'h8);
    step(); idle(1); idle(3); #1;
    step(); #1;
    chk("R4 late_ack core3", 32'(late_ack), 32'h8);
  endtask

  task automatic t_round_robin();
    for (int k = 0; k < 6; k++) begin
      step(); drive(0, 1, 10, 32'(k)); drive(2, 1, 11, 32'(k)); #1;
      chk($sformatf("R7 alternation step %0d", k), 32'(wr_ack),
          (k % 2 == 0) ? 32'h1 : 32'h4);
    end
    step(); idle(0); idle(2); #1;
    repeat (4) step();
  endtask

  task automatic t_order();
    logic [NC-1:0] pend = 4'b1110;
    logic [NC-1:0] ack_h [10];
    logic [NC-1:0] late_h [10];
    logic [NC-1:0] seen = '0;
    for (int cyc = 0; cyc < 10; cyc++) begin
      step();
      for (int c = 0; c < NC; c++) begin
        if (pend[c]) drive(c, 1, 12 + c, 32'h100 + 32'(c));
        else idle(c);
      end
      #1;
      ack_h[cyc]  = wr_ack;
      late_h[cyc] = late_ack;
      pend = pend & ~wr_ack;
      seen = seen | wr_ack;
      chk($sformatf("R7 one grant cycle %0d", cyc), 32'($countones(wr_ack) <= 1), 1);
    end
    chk("R7 every requester granted", 32'(seen), 32'hE);
    for (int k = 0; k < 8; k++)
      chk($sformatf("R3 late order slot %0d", k), 32'(late_h[k+2]), 32'(ack_h[k]));
    for (int c = 1; c < NC; c++) begin
      step(); drive(0, 0, 12 + c, 0); #1;
      step(); #1;
      chk($sformatf("R3 word of core %0d", c), rd_data, 32'h100 + 32'(c));
      step(); idle(0); #1;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = '0; req_write = '0; req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    t_reset();
    t_write_read();
    t_own_wait();
    t_drain_prio();
    t_round_robin();
    t_order();
    repeat (3) step();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule